// File: doc/BRIEF.md
# Display Data Channel I2C Slave with Byte Stalling

This block is a byte-oriented I2C slave for a monitor's display data channel. It samples the bus clock and data lines with the system clock, cleans them up, and finds START, repeated START and STOP. It receives the address byte and compares it with a fixed default address and one address that software programs. It acknowledges the bytes it receives. On bytes it sends, it captures the master's acknowledge.

After every ninth bus clock the block raises a per-byte flag and holds the bus clock low. This gives software time to service the data register. Software reads the received byte, or loads the next byte to send, by writing the data register, and that write releases the clock. Software sets the transfer direction from the R/W bit of the address byte. The pins are open-drain: the block only drives each line low through an enable output.

Register map for the `wr_addr`/`rd_addr` offsets: 0 DATA, 1 OWN (programmable 7-bit address in bits 6:0), 2 STATUS (bit0 start seen, bit1 address hit, bit2 byte done, bit3 received acknowledge; bits 0 to 2 are cleared by writing 1), 3 CTRL (bit0 enable, bit1 transmit, bit2 address interrupt enable, bit3 byte interrupt enable).

Top module: `ddc_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) sets STATUS bit0. The bit stays 1 until software writes 1 to STATUS bit0.
- R2: A repeated START with no STOP before it restarts address reception, so a new address byte is matched as after a first START.
- R3: The first byte after START is taken MSB first. Its upper 7 bits are compared with 7'h50 and with OWN[6:0]. A hit on either sets STATUS bit1 and stores the whole byte in DATA.
- R4: On an address hit the block drives SDA low through the ninth clock.
- R5: `irq_addr` rises on an address hit only if CTRL bit2 was already 1 at the hit. Setting CTRL bit2 later does not raise it. Writing 1 to STATUS bit1 clears it.
- R6: In receive mode (CTRL bit1 = 0), every data byte is stored in DATA and acknowledged by driving SDA low on its ninth clock. SDA only starts being driven while SCL is low.
- R7: In transmit mode (CTRL bit1 = 1), a DATA write during the stall loads the byte, and the block shifts it out MSB first, with each bit changing while SCL is low.
- R8: At the falling edge of each ninth clock after an address hit, STATUS bit2 is set and SCL is held low until software writes DATA. `irq_byte` is STATUS bit2 AND CTRL bit3.
- R9: In transmit mode, SDA sampled on the ninth clock is stored in STATUS bit3 (0 = acknowledged). After a not-acknowledge, SCL is not held, SDA is released, and no further data is driven until STOP or START.
- R10: A STOP (SDA rising while SCL is high) returns the block to idle with both line drives released.
- R11: On an address miss the block gives no acknowledge, sets no flag, raises no interrupt, and ignores all bus activity until the next START.
- R12: With CTRL bit0 = 0 the block drives neither line and does not record START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| scl_drive_low | output | 1 | Pull bus clock low when 1 |
| sda_drive_low | output | 1 | Pull bus data low when 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 8 | Register write value |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 8 | Register read value (combinational) |
| irq_addr | output | 1 | Address-hit interrupt |
| irq_byte | output | 1 | Per-byte interrupt |

## Verification
The bench uses the default parameters: fixed address 7'h50, two synchronizer stages and a two-sample filter. With these, the input latency is a few system clocks, so a bus half-period of 20 system clocks leaves margin for the acknowledge drive and the stall to take effect before the master's next edge. The programmable address is set to 7'h37 to reach the second comparator. The fixed address is used for the other transfers, and a miss address exercises the ignore path ahead of a repeated START.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_OWN  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_CTRL = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK, ST_RX, ST_TX, ST_TXACK, ST_HOLD, ST_SKIP
    } ddc_state_e;

    typedef struct packed {
        ddc_state_e             st;
        logic [BYTE_BITS-1:0]   sh;
        logic [CNT_W-1:0]       cnt;
        logic [BYTE_BITS-1:0]   data;
        logic [6:0]             own;
        logic                   start_seen;
        logic                   addr_hit;
        logic                   byte_flag;
        logic                   rxak;
        logic                   irq_addr;
        logic                   en;
        logic                   trx;
        logic                   aie;
        logic                   bie;
        logic                   hold;
        logic                   sda_low;
        logic                   scl_p;
        logic                   sda_p;
    } ddc_regs_t;

endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
    parameter int LINES        = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [SYNC_STAGES-1:0]  sync_q;
        logic [FILT_SAMPLES-1:0] hist_q;
        logic                    clean_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q  <= '1;
                hist_q  <= '1;
                clean_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], raw[i]};
                hist_q <= {hist_q[FILT_SAMPLES-2:0], sync_q[SYNC_STAGES-1]};
                if (&hist_q) begin
                    clean_q <= 1'b1;
                end else if (~|hist_q) begin
                    clean_q <= 1'b0;
                end
            end
        end

        assign clean[i] = clean_q;
    end

endmodule

// File: rtl/ddc_addr_match.sv
module ddc_addr_match #(
    parameter logic [6:0] DEF_ADDR = 7'h50
) (
    input  logic [7:0] addr_byte,
    input  logic [6:0] own_addr,
    output logic       hit
);

    logic [6:0] target;

    always_comb begin
        target = addr_byte[7:1];
        hit    = (target == DEF_ADDR) || (target == own_addr);
    end

endmodule

// File: rtl/ddc_slave.sv
module ddc_slave
    import ddc_pkg::*;
#(
    parameter logic [6:0] DEF_ADDR     = 7'h50,
    parameter int         SYNC_STAGES  = 2,
    parameter int         FILT_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq_addr,
    output logic       irq_byte
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    ddc_regs_t r_d, r_q;
    logic [1:0] lines_f;
    logic       scl_f, sda_f;
    logic       rise_ev, fall_ev, start_ev, stop_ev, hit;
    logic [7:0] nsh;
    logic [CNT_W-1:0] ncnt;

    ddc_line_filter #(
        .LINES        (2),
        .SYNC_STAGES  (SYNC_STAGES),
        .FILT_SAMPLES (FILT_SAMPLES)
    ) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sda_in, scl_in}),
        .clean (lines_f)
    );

    assign scl_f = lines_f[0];
    assign sda_f = lines_f[1];

    ddc_addr_match #(.DEF_ADDR(DEF_ADDR)) match_i (
        .addr_byte (r_q.sh),
        .own_addr  (r_q.own),
        .hit       (hit)
    );

    always_comb begin
        rise_ev  = scl_f && !r_q.scl_p;
        fall_ev  = !scl_f && r_q.scl_p;
        start_ev = scl_f && r_q.scl_p && r_q.sda_p && !sda_f;
        stop_ev  = scl_f && r_q.scl_p && !r_q.sda_p && sda_f;
        nsh      = {r_q.sh[6:0], 1'b0};
        ncnt     = r_q.cnt + 1'b1;

        r_d       = r_q;
        r_d.scl_p = scl_f;
        r_d.sda_p = sda_f;

        // software side
        if (wr_en) begin
            case (wr_addr)
                REG_DATA: begin
                    r_d.data = wr_data;
                    if (r_q.st == ST_HOLD) begin
                        r_d.byte_flag = 1'b0;
                        r_d.hold      = 1'b0;
                        r_d.cnt       = '0;
                        if (r_q.trx) begin
                            r_d.sh      = wr_data;
                            r_d.sda_low = !wr_data[7];
                            r_d.st      = ST_TX;
                        end else begin
                            r_d.st = ST_RX;
                        end
                    end
                end
                REG_OWN:  r_d.own = wr_data[6:0];
                REG_STAT: begin
                    if (wr_data[0]) r_d.start_seen = 1'b0;
                    if (wr_data[1]) begin
                        r_d.addr_hit = 1'b0;
                        r_d.irq_addr = 1'b0;
                    end
                    if (wr_data[2]) r_d.byte_flag = 1'b0;
                end
                default: begin
                    r_d.en  = wr_data[0];
                    r_d.trx = wr_data[1];
                    r_d.aie = wr_data[2];
                    r_d.bie = wr_data[3];
                end
            endcase
        end

        // bus side, takes priority over software
        if (!r_q.en) begin
            r_d.st      = ST_IDLE;
            r_d.hold    = 1'b0;
            r_d.sda_low = 1'b0;
        end else if (start_ev) begin
            r_d.start_seen = 1'b1;
            r_d.st         = ST_ADDR;
            r_d.cnt        = '0;
            r_d.hold       = 1'b0;
            r_d.sda_low    = 1'b0;
        end else if (stop_ev) begin
            r_d.st      = ST_IDLE;
            r_d.hold    = 1'b0;
            r_d.sda_low = 1'b0;
        end else begin
            case (r_q.st)
                ST_ADDR, ST_RX: begin
                    if (rise_ev && r_q.cnt < LAST_BIT) begin
                        r_d.sh  = {r_q.sh[6:0], sda_f};
                        r_d.cnt = ncnt;
                    end else if (fall_ev && r_q.cnt == LAST_BIT) begin
                        if (r_q.st == ST_RX || hit) begin
                            r_d.data    = r_q.sh;
                            r_d.sda_low = 1'b1;
                            r_d.st      = ST_ACK;
                            if (r_q.st == ST_ADDR) begin
                                r_d.addr_hit = 1'b1;
                                r_d.irq_addr = r_q.irq_addr || r_q.aie;
                            end
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall_ev) begin
                        r_d.sda_low   = 1'b0;
                        r_d.byte_flag = 1'b1;
                        r_d.hold      = 1'b1;
                        r_d.st        = ST_HOLD;
                    end
                end
                ST_TX: begin
                    if (fall_ev) begin
                        r_d.sh  = nsh;
                        r_d.cnt = ncnt;
                        if (ncnt == LAST_BIT) begin
                            r_d.sda_low = 1'b0;
                            r_d.st      = ST_TXACK;
                        end else begin
                            r_d.sda_low = !nsh[7];
                        end
                    end
                end
                ST_TXACK: begin
                    if (rise_ev) begin
                        r_d.rxak = sda_f;
                    end else if (fall_ev) begin
                        r_d.byte_flag = 1'b1;
                        if (r_q.rxak) begin
                            r_d.st = ST_SKIP;
                        end else begin
                            r_d.hold = 1'b1;
                            r_d.st   = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.scl_p <= 1'b1;
            r_q.sda_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (rd_addr)
            REG_DATA: rd_data = r_q.data;
            REG_OWN:  rd_data = {1'b0, r_q.own};
            REG_STAT: rd_data = {4'b0, r_q.rxak, r_q.byte_flag, r_q.addr_hit, r_q.start_seen};
            default:  rd_data = {4'b0, r_q.bie, r_q.aie, r_q.trx, r_q.en};
        endcase
    end

    assign scl_drive_low = r_q.hold;
    assign sda_drive_low = r_q.sda_low;
    assign irq_addr      = r_q.irq_addr;
    assign irq_byte      = r_q.byte_flag && r_q.bie;

    // start status survives until software clears it
    assert_start_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.start_seen && !(wr_en && wr_addr == REG_STAT && wr_data[0])) |=> r_q.start_seen);

    // interrupt line never stands without the hit flag behind it
    assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_addr |-> r_q.addr_hit);

    // data drive only begins while the filtered clock is low
    assert_sda_onset_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_f);

    // the stall is only ever applied over a low clock phase
    assert_hold_over_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> !scl_f);

    // a disabled block lets go of both lines
    assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.en |=> (!sda_drive_low && !scl_drive_low));

endmodule

// File: tb/ddc_slave_tb_top.sv
`timescale 1ns/1ps
module ddc_slave_tb_top;

    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       scl_low, sda_low;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0, rd_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq_addr, irq_byte;
    logic       scl_bus, sda_bus;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    assign scl_bus = scl_m & ~scl_low;
    assign sda_bus = sda_m & ~sda_low;

    always #10 clk = ~clk;

    ddc_slave dut_i (
        .clk (clk), .rst_n (rst_n),
        .scl_in (scl_bus), .sda_in (sda_bus),
        .scl_drive_low (scl_low), .sda_drive_low (sda_low),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .irq_addr (irq_addr), .irq_byte (irq_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wait_cyc(2);
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_clock(input logic b, output logic s);
        sda_m = b;
        wait_cyc(H);
        scl_m = 1'b1;
        wait_scl_high();
        wait_cyc(H / 2);
        s = sda_bus;
        wait_cyc(H / 2);
        scl_m = 1'b0;
        wait_cyc(H);
    endtask

    task automatic m_start();
        sda_m = 1'b1;
        wait_cyc(H);
        scl_m = 1'b1;
        wait_scl_high();
        wait_cyc(H);
        sda_m = 1'b0;
        wait_cyc(H);
        scl_m = 1'b0;
        wait_cyc(H);
    endtask

    task automatic m_stop();
        sda_m = 1'b0;
        wait_cyc(H);
        scl_m = 1'b1;
        wait_scl_high();
        wait_cyc(H);
        sda_m = 1'b1;
        wait_cyc(H);
    endtask

    task automatic m_send(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) m_clock(v[i], s);
        m_clock(1'b1, s);
        acked = !s;
    endtask

    task automatic m_recv(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_clock(1'b1, s);
            v[i] = s;
        end
        m_clock(!give_ack, s);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(2'd2, v);
        chk("R1 reset status", v, 8'h00);
        chk("R10 reset scl drive", scl_low, 1'b0);
        chk("R10 reset sda drive", sda_low, 1'b0);
        chk("R5 reset irq_addr", irq_addr, 1'b0);
    endtask

    task automatic t_write_default();
        logic a;
        logic [7:0] v;
        reg_wr(2'd3, 8'h0D);
        m_start();
        reg_rd(2'd2, v);
        chk("R1 start recorded", v[0], 1'b1);
        m_send(8'hA0, a);
        chk("R4 address ack", a, 1'b1);
        reg_rd(2'd0, v);
        chk("R3 address byte stored", v, 8'hA0);
        reg_rd(2'd2, v);
        chk("R3 hit flag", v[1], 1'b1);
        chk("R8 byte flag", v[2], 1'b1);
        chk("R5 irq_addr enabled", irq_addr, 1'b1);
        chk("R8 irq_byte", irq_byte, 1'b1);
        chk("R8 scl stalled", scl_low, 1'b1);
        wait_cyc(3 * H);
        chk("R8 stall persists", scl_bus, 1'b0);
        reg_wr(2'd0, 8'h00);
        chk("R8 released by data write", scl_low, 1'b0);
        m_send(8'h3C, a);
        chk("R6 data ack", a, 1'b1);
        reg_rd(2'd0, v);
        chk("R6 data stored", v, 8'h3C);
        chk("R8 stall after data byte", scl_low, 1'b1);
        reg_wr(2'd0, 8'h00);
        m_stop();
        chk("R10 scl free after stop", scl_low, 1'b0);
        chk("R10 sda free after stop", sda_low, 1'b0);
        reg_rd(2'd2, v);
        chk("R1 start still set", v[0], 1'b1);
        reg_wr(2'd2, 8'h07);
        reg_rd(2'd2, v);
        chk("R1 start cleared", v[0], 1'b0);
        chk("R5 irq cleared", irq_addr, 1'b0);
    endtask

    task automatic t_read_own();
        logic a;
        logic [7:0] v;
        reg_wr(2'd1, 8'h37);
        reg_wr(2'd3, 8'h09);
        m_start();
        m_send(8'h6F, a);
        chk("R3 own address ack", a, 1'b1);
        reg_wr(2'd3, 8'h0B);
        reg_wr(2'd0, 8'hC5);
        m_recv(1'b1, v);
        chk("R7 first byte out", v, 8'hC5);
        reg_rd(2'd2, v);
        chk("R9 ack captured", v[3], 1'b0);
        chk("R8 stall in transmit", scl_low, 1'b1);
        reg_wr(2'd0, 8'h5A);
        m_recv(1'b0, v);
        chk("R7 second byte out", v, 8'h5A);
        reg_rd(2'd2, v);
        chk("R9 nack captured", v[3], 1'b1);
        chk("R9 no stall after nack", scl_low, 1'b0);
        chk("R9 sda released", sda_low, 1'b0);
        m_recv(1'b0, v);
        chk("R9 nothing driven after nack", v, 8'hFF);
        m_stop();
        reg_wr(2'd2, 8'h07);
        reg_wr(2'd3, 8'h0D);
    endtask

    task automatic t_miss_restart();
        logic a;
        logic [7:0] v;
        m_start();
        m_send(8'h44, a);
        chk("R11 miss not acked", a, 1'b0);
        reg_rd(2'd2, v);
        chk("R11 no hit flag", v[2:1], 2'b00);
        chk("R11 no irq", irq_addr, 1'b0);
        chk("R11 no stall", scl_low, 1'b0);
        m_send(8'hA0, a);
        chk("R11 later byte ignored", a, 1'b0);
        m_start();
        m_send(8'hA0, a);
        chk("R2 repeated start matches", a, 1'b1);
        reg_wr(2'd0, 8'h00);
        m_stop();
        reg_wr(2'd2, 8'h07);
    endtask

    task automatic t_late_enable();
        logic a;
        logic [7:0] v;
        reg_wr(2'd3, 8'h01);
        m_start();
        m_send(8'hA0, a);
        reg_rd(2'd2, v);
        chk("R5 flag without enable", v[1], 1'b1);
        chk("R5 irq masked", irq_addr, 1'b0);
        reg_wr(2'd3, 8'h05);
        chk("R5 late enable no irq", irq_addr, 1'b0);
        reg_wr(2'd0, 8'h00);
        m_stop();
        reg_wr(2'd2, 8'h07);
    endtask

    task automatic t_disabled();
        logic a;
        logic [7:0] v;
        reg_wr(2'd3, 8'h00);
        m_start();
        m_send(8'hA0, a);
        chk("R12 no ack when off", a, 1'b0);
        reg_rd(2'd2, v);
        chk("R12 no start when off", v[0], 1'b0);
        m_stop();
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset();
        t_write_default();
        t_read_own();
        t_miss_restart();
        t_late_enable();
        t_disabled();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule